// File: doc/BRIEF.md
# Flash Block Erase Command Front End

This block is the device-side command path of a small flash array. It accepts command and address bytes, each qualified by a one-cycle write strobe and by a command-latch or address-latch qualifier. It recognises a block erase sequence and runs the erase for a fixed number of clock cycles. The erase writes all ones into one block of an internal word store. An active-low ready/busy output shows when an operation is running. A status byte is returned on a read strobe once the read-status command has been given.

A reset command aborts a running erase and clears the command state and the status bits. The ready/busy output then stays low for a while, and that time is longer when an erase was interrupted than when the device was idle. A reset sent while the device is already in its reset state is dropped. A per-block lock mask makes the erase of that block leave the data untouched and report failure.

A word-wide host port writes and reads the store directly. The bench uses it to load patterns and to inspect the result of an erase.

Top module: `nand_erase_ctl`

## Requirements
- R1: The command byte 60h, then ADDR_CYCLES (default 2) address bytes, then the command byte D0h starts an erase. `rb_n` reads 0 from the clock edge that samples the D0h byte.
- R2: An erase keeps `rb_n` low for exactly ERASE_CYCLES (default 40) cycles. After that `rb_n` is 1 and status bit 6 reads 1.
- R3: The block number is taken from row bits [3:2], which are bits [3:2] of the first address byte. Row bits [1:0] (page within the block) and all higher row bits are ignored.
- R4: When an erase completes, every word of the addressed block reads FFh on the host port. Words of other blocks keep their contents.
- R5: While `rb_n` is low, only 70h and FFh are acted on. Every other command byte, and every address byte, changes neither the status mode nor the command sequence.
- R6: After the command 70h, each `io_rd` pulse loads `io_dout` with the status byte. In that byte, bit 6 is 1 when ready, bit 0 is 1 when the last erase failed, and every other bit is 0. After any other accepted command, `io_rd` loads 00h.
- R7: An erase of a block whose `blk_lock` bit is set leaves that block's data unchanged. It still takes ERASE_CYCLES and ends with status bit 0 set to 1.
- R8: FFh sent when the device is idle but not in its reset state drives `rb_n` low for RST_IDLE_CYCLES (default 3). It also clears status bit 0 and leaves status mode.
- R9: FFh sent during an erase aborts the erase and holds `rb_n` low for RST_ABORT_CYCLES (default 12). After that the device is ready.
- R10: FFh is ignored, and `rb_n` stays 1, in two cases: after the synchronous reset, and after an earlier reset command, as long as no 60h has been accepted since.
- R11: A command byte other than D0h given after the address bytes cancels the sequence. No busy period follows and no data changes.
- R12: After the synchronous reset, `rb_n` is 1 and `io_dout` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_we | input | 1 | One-cycle write strobe for a command or address byte |
| io_cle | input | 1 | Byte is a command |
| io_ale | input | 1 | Byte is an address |
| io_din | input | 8 | Command or address byte |
| io_rd | input | 1 | Read strobe, loads io_dout |
| io_dout | output | 8 | Status byte or 00h |
| rb_n | output | 1 | Ready (1) / busy (0) |
| blk_lock | input | NUM_BLOCKS | Per-block lock; a locked erase fails |
| arr_we | input | 1 | Host word write |
| arr_addr | input | BLK_BITS+WORD_BITS | Host word address {block, word} |
| arr_wdata | input | 8 | Host write data |
| arr_rdata | output | 8 | Registered host read data |

## Verification
If the sequence state is wrong, for example stuck in address or confirm, the ports show it within one command. A D0h either fails to pull `rb_n` low at the sampling edge, or a cancelled sequence pulls it low. A wrong operation counter shows up as a busy period of the wrong length, measured in whole cycles. A wrong reset-state flag shows up when FFh either fails to drop `rb_n` or drops it when it should not. The erase write walker and the lock path are only visible through host-port reads taken after `rb_n` rises. A bad status-mode flag appears on the next `io_rd` as 00h where a status byte was expected, or the reverse.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADDR, SEQ_CONF} seq_e;
  typedef enum logic [1:0] {OPK_NONE, OPK_ERASE, OPK_RESET} opk_e;
endpackage

// File: rtl/nec_cmd_seq.sv
module nec_cmd_seq
  import nand_erase_pkg::*;
#(
  parameter int ADDR_CYCLES = 2,
  parameter int PAGE_BITS   = 2,
  parameter int BLK_BITS    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                cle,
  input  logic                ale,
  input  logic [7:0]          din,
  input  logic                busy,
  output logic                erase_go,
  output logic                rst_go,
  output logic                stat_mode,
  output logic [BLK_BITS-1:0] blk_sel
);
  localparam int ROW_W = 8 * ADDR_CYCLES;
  localparam int ACW   = $clog2(ADDR_CYCLES + 1);

  seq_e             seq_q;
  logic [ACW-1:0]   acnt_q;
  logic [ROW_W-1:0] row_q;
  logic             fresh_q;
  logic             stat_q;
  logic             cmd_ev, adr_ev, cmd_ok;
  logic             unused_row;

  assign cmd_ev    = wr_en && cle && !ale;
  assign adr_ev    = wr_en && ale && !cle;
  assign cmd_ok    = cmd_ev && !busy && (din != OP_RESET);
  assign rst_go    = cmd_ev && (din == OP_RESET) && !fresh_q;
  assign erase_go  = cmd_ok && (seq_q == SEQ_CONF) && (din == OP_ERASE_GO);
  assign blk_sel   = row_q[PAGE_BITS +: BLK_BITS];
  assign stat_mode = stat_q;
  assign unused_row = ^row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= SEQ_IDLE;
      acnt_q  <= '0;
      row_q   <= '0;
      fresh_q <= 1'b1;
      stat_q  <= 1'b0;
    end else if (rst_go) begin
      seq_q   <= SEQ_IDLE;
      stat_q  <= 1'b0;
      fresh_q <= 1'b1;
    end else if (cmd_ev && din == OP_READ_STATUS) begin
      stat_q <= 1'b1;
      if (!busy) seq_q <= SEQ_IDLE;
    end else if (cmd_ok) begin
      stat_q <= 1'b0;
      if (din == OP_ERASE_SETUP) begin
        seq_q   <= SEQ_ADDR;
        acnt_q  <= '0;
        row_q   <= '0;
        fresh_q <= 1'b0;
      end else begin
        seq_q <= SEQ_IDLE;
      end
    end else if (adr_ev && !busy && seq_q == SEQ_ADDR) begin
      row_q[{acnt_q, 3'b000} +: 8] <= din;
      acnt_q <= acnt_q + 1'b1;
      if (acnt_q == ACW'(ADDR_CYCLES - 1)) seq_q <= SEQ_CONF;
    end
  end

  // R1: the last address byte moves the sequence to confirm
  p_addr_to_conf_r1: assert property (@(posedge clk) disable iff (rst)
    (seq_q == SEQ_ADDR && adr_ev && !busy && acnt_q == ACW'(ADDR_CYCLES - 1))
      |=> seq_q == SEQ_CONF);

  // R5: a filtered command while busy leaves the interface untouched
  p_busy_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_ev && din != OP_RESET && din != OP_READ_STATUS)
      |=> ($stable(seq_q) && $stable(stat_q) && $stable(fresh_q)));

  // R10: a reset in the reset state keeps that state
  p_fresh_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (fresh_q && cmd_ev && din == OP_RESET) |=> (fresh_q && seq_q == SEQ_IDLE));
endmodule

// File: rtl/nec_op_timer.sv
module nec_op_timer
  import nand_erase_pkg::*;
#(
  parameter int BLK_BITS         = 2,
  parameter int WORDS_PER_BLOCK  = 8,
  parameter int ERASE_CYCLES     = 40,
  parameter int RST_IDLE_CYCLES  = 3,
  parameter int RST_ABORT_CYCLES = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 erase_go,
  input  logic                 rst_go,
  input  logic [BLK_BITS-1:0]  blk_in,
  input  logic                 fail_in,
  output logic                 busy,
  output logic                 rb_n,
  output logic                 ers_we,
  output logic [BLK_BITS+$clog2(WORDS_PER_BLOCK)-1:0] ers_addr,
  output logic                 ers_done,
  output logic                 ers_fail
);
  localparam int WORD_BITS = $clog2(WORDS_PER_BLOCK);
  localparam int MAX_A = (ERASE_CYCLES > RST_ABORT_CYCLES) ? ERASE_CYCLES : RST_ABORT_CYCLES;
  localparam int MAX_C = (MAX_A > RST_IDLE_CYCLES) ? MAX_A : RST_IDLE_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [WORD_BITS:0] WEND = WORD_BITS'(WORDS_PER_BLOCK - 1) + 1'b1;

  opk_e                kind_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [WORD_BITS:0]  widx_q;
  logic [BLK_BITS-1:0] blk_q;
  logic                fail_q;
  logic                rb_q;
  logic                last;

  assign busy     = (kind_q != OPK_NONE);
  assign rb_n     = rb_q;
  assign last     = (cnt_q == CNT_W'(1));
  assign ers_we   = (kind_q == OPK_ERASE) && !fail_q && (widx_q < WEND);
  assign ers_addr = {blk_q, widx_q[WORD_BITS-1:0]};
  assign ers_done = (kind_q == OPK_ERASE) && last;
  assign ers_fail = fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= OPK_NONE;
      cnt_q  <= '0;
      widx_q <= '0;
      blk_q  <= '0;
      fail_q <= 1'b0;
      rb_q   <= 1'b1;
    end else if (rst_go) begin
      kind_q <= OPK_RESET;
      cnt_q  <= (kind_q == OPK_ERASE) ? CNT_W'(RST_ABORT_CYCLES) : CNT_W'(RST_IDLE_CYCLES);
      rb_q   <= 1'b0;
    end else if (erase_go) begin
      kind_q <= OPK_ERASE;
      cnt_q  <= CNT_W'(ERASE_CYCLES);
      widx_q <= '0;
      blk_q  <= blk_in;
      fail_q <= fail_in;
      rb_q   <= 1'b0;
    end else if (kind_q != OPK_NONE) begin
      cnt_q <= cnt_q - 1'b1;
      if (widx_q < WEND) widx_q <= widx_q + 1'b1;
      if (last) begin
        kind_q <= OPK_NONE;
        rb_q   <= 1'b1;
      end
    end
  end

  // R1: the confirm edge makes the device busy
  p_go_busy_r1: assert property (@(posedge clk) disable iff (rst)
    erase_go |=> (!rb_q && busy));

  // R2: the last erase cycle returns ready
  p_end_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (kind_q == OPK_ERASE && last && !rst_go) |=> (rb_q && !busy));

  // R9: an abort loads the long reset time
  p_abort_len_r9: assert property (@(posedge clk) disable iff (rst)
    (rst_go && kind_q == OPK_ERASE) |=> (cnt_q == CNT_W'(RST_ABORT_CYCLES) && !rb_q));
endmodule

// File: rtl/nec_block_store.sv
module nec_block_store #(
  parameter int DATA_W = 8,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              ers_we,
  input  logic [AW-1:0]     ers_addr,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              we;
  logic [AW-1:0]     waddr;
  logic [DATA_W-1:0] wdata;

  // single write port, erase has priority over the host
  assign we    = ers_we || host_we;
  assign waddr = ers_we ? ers_addr : host_addr;
  assign wdata = ers_we ? '1 : host_wdata;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    host_rdata <= mem[host_addr];
  end
endmodule

// File: rtl/nand_erase_ctl.sv
module nand_erase_ctl
  import nand_erase_pkg::*;
#(
  parameter int NUM_BLOCKS       = 4,
  parameter int PAGES_PER_BLOCK  = 4,
  parameter int WORDS_PER_BLOCK  = 8,
  parameter int ADDR_CYCLES      = 2,
  parameter int ERASE_CYCLES     = 40,
  parameter int RST_IDLE_CYCLES  = 3,
  parameter int RST_ABORT_CYCLES = 12,
  localparam int BLK_BITS  = $clog2(NUM_BLOCKS),
  localparam int WORD_BITS = $clog2(WORDS_PER_BLOCK),
  localparam int AW        = BLK_BITS + WORD_BITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  io_we,
  input  logic                  io_cle,
  input  logic                  io_ale,
  input  logic [7:0]            io_din,
  input  logic                  io_rd,
  output logic [7:0]            io_dout,
  output logic                  rb_n,
  input  logic [NUM_BLOCKS-1:0] blk_lock,
  input  logic                  arr_we,
  input  logic [AW-1:0]         arr_addr,
  input  logic [7:0]            arr_wdata,
  output logic [7:0]            arr_rdata
);
  localparam int PAGE_BITS = $clog2(PAGES_PER_BLOCK);

  logic                erase_go, rst_go, stat_mode, busy;
  logic [BLK_BITS-1:0] blk_sel;
  logic                ers_we, ers_done, ers_fail;
  logic [AW-1:0]       ers_addr;
  logic                fail_q;
  logic [7:0]          dout_q;

  nec_cmd_seq #(
    .ADDR_CYCLES(ADDR_CYCLES), .PAGE_BITS(PAGE_BITS), .BLK_BITS(BLK_BITS)
  ) i_seq (
    .clk(clk), .rst(rst), .wr_en(io_we), .cle(io_cle), .ale(io_ale),
    .din(io_din), .busy(busy), .erase_go(erase_go), .rst_go(rst_go),
    .stat_mode(stat_mode), .blk_sel(blk_sel)
  );

  nec_op_timer #(
    .BLK_BITS(BLK_BITS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
    .ERASE_CYCLES(ERASE_CYCLES), .RST_IDLE_CYCLES(RST_IDLE_CYCLES),
    .RST_ABORT_CYCLES(RST_ABORT_CYCLES)
  ) i_timer (
    .clk(clk), .rst(rst), .erase_go(erase_go), .rst_go(rst_go),
    .blk_in(blk_sel), .fail_in(blk_lock[blk_sel]), .busy(busy), .rb_n(rb_n),
    .ers_we(ers_we), .ers_addr(ers_addr), .ers_done(ers_done), .ers_fail(ers_fail)
  );

  nec_block_store #(.DATA_W(8), .AW(AW)) i_store (
    .clk(clk), .ers_we(ers_we), .ers_addr(ers_addr), .host_we(arr_we),
    .host_addr(arr_addr), .host_wdata(arr_wdata), .host_rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
      dout_q <= '0;
    end else begin
      if (rst_go || erase_go) fail_q <= 1'b0;
      else if (ers_done)      fail_q <= ers_fail;
      if (io_rd) dout_q <= stat_mode ? {1'b0, rb_n, 5'b00000, fail_q} : 8'h00;
    end
  end

  assign io_dout = dout_q;

  // R6: a status read reports readiness in bit 6
  p_status_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (io_rd && stat_mode) |=> (io_dout[6] == $past(rb_n) && io_dout[5:1] == 5'b0));

  // R7: a locked erase never writes the store
  p_lock_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (erase_go && blk_lock[blk_sel]) |=> !ers_we);
endmodule

// File: tb/test_nand_erase_ctl.sv
`timescale 1ns/1ps
module test_nand_erase_ctl;
  localparam int NB = 4, WPB = 8, AW = 5;
  localparam int ERASE = 40, RIDLE = 3, RABORT = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_we = 0, io_cle = 0, io_ale = 0, io_rd = 0;
  logic [7:0] io_din = 0;
  logic [7:0] io_dout;
  logic rb_n;
  logic [NB-1:0] blk_lock = '0;
  logic arr_we = 0;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0] arr_wdata = 0;
  logic [7:0] arr_rdata;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  nand_erase_ctl i_nand_erase_ctl (
    .clk(clk), .rst(rst), .io_we(io_we), .io_cle(io_cle), .io_ale(io_ale),
    .io_din(io_din), .io_rd(io_rd), .io_dout(io_dout), .rb_n(rb_n),
    .blk_lock(blk_lock), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); io_we = 1; io_cle = 1; io_ale = 0; io_din = b;
    @(negedge clk); io_we = 0; io_cle = 0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(negedge clk); io_we = 1; io_ale = 1; io_cle = 0; io_din = b;
    @(negedge clk); io_we = 0; io_ale = 0;
  endtask

  task automatic read_dout(output logic [7:0] v);
    @(negedge clk); io_rd = 1;
    @(negedge clk); io_rd = 0; v = io_dout;
  endtask

  task automatic wr_word(input int a, input logic [7:0] d);
    @(negedge clk); arr_we = 1; arr_addr = AW'(a); arr_wdata = d;
    @(negedge clk); arr_we = 0;
  endtask

  task automatic rd_word(input int a, output logic [7:0] d);
    @(negedge clk); arr_addr = AW'(a);
    @(negedge clk); d = arr_rdata;
  endtask

  // counts the cycles rb_n stays low, starting at the negedge after a command
  task automatic busy_len(output int n);
    n = 0;
    while (rb_n == 1'b0 && n < 500) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic stays_ready(input string req);
    int lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (!rb_n) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  task automatic start_erase(input logic [7:0] a0, input logic [7:0] a1);
    send_cmd(8'h60); send_addr(a0); send_addr(a1); send_cmd(8'hD0);
  endtask

  task automatic check_block(input int blk, input bit erased, input string req);
    logic [7:0] d;
    int bad = 0; int last = 0;
    for (int w = 0; w < WPB; w++) begin
      rd_word(blk * WPB + w, d);
      if (d != (erased ? 8'hFF : pat(blk * WPB + w))) begin bad++; last = int'(d); end
    end
    check(bad == 0, req, last, erased ? 8'hFF : pat(blk * WPB));
  endtask

  task automatic t_reset_state;
    logic [7:0] v;
    check(rb_n == 1'b1, "R12 rb_n after reset", rb_n, 1);
    read_dout(v);
    check(v == 8'h00, "R12 io_dout after reset", v, 0);
    send_cmd(8'hFF);
    stays_ready("R10 reset ignored after power-up reset");
  endtask

  task automatic t_fill;
    logic [7:0] d;
    for (int a = 0; a < NB * WPB; a++) wr_word(a, pat(a));
    rd_word(13, d);
    check(d == pat(13), "R4 host port load", d, pat(13));
  endtask

  task automatic t_erase_basic;
    int n; logic [7:0] v;
    // row 0x5A0B: page 3 of block 2, upper bits ignored (R3)
    start_erase(8'h0B, 8'h5A);
    check(rb_n == 1'b0, "R1 busy from confirm edge", rb_n, 0);
    busy_len(n);
    check(n == ERASE, "R2 erase busy length", n, ERASE);
    send_cmd(8'h70); read_dout(v);
    check(v == 8'h40, "R2 R6 status after erase", v, 8'h40);
    check_block(2, 1, "R4 R3 block 2 erased");
    check_block(1, 0, "R4 R3 block 1 kept");
    check_block(3, 0, "R4 R3 block 3 kept");
  endtask

  task automatic t_busy_filter;
    int n; logic [7:0] v;
    start_erase(8'h00, 8'h00);
    send_cmd(8'h70); read_dout(v);
    check(v == 8'h00, "R6 status busy", v, 8'h00);
    send_cmd(8'h60); send_addr(8'h04); send_addr(8'h00); send_cmd(8'hD0);
    busy_len(n);
    read_dout(v);
    check(v == 8'h40, "R5 setup ignored while busy", v, 8'h40);
    stays_ready("R5 no erase from commands sent while busy");
    check_block(0, 1, "R4 block 0 erased");
    check_block(1, 0, "R5 block 1 untouched");
  endtask

  task automatic t_fail_and_reset;
    int n; logic [7:0] v;
    blk_lock = 4'b0010;
    start_erase(8'h04, 8'h00);
    busy_len(n);
    check(n == ERASE, "R7 locked erase length", n, ERASE);
    send_cmd(8'h70); read_dout(v);
    check(v == 8'h41, "R7 fail bit", v, 8'h41);
    check_block(1, 0, "R7 locked block kept");
    blk_lock = '0;
    send_cmd(8'hFF);
    busy_len(n);
    check(n == RIDLE, "R8 idle reset length", n, RIDLE);
    read_dout(v);
    check(v == 8'h00, "R8 status mode left", v, 8'h00);
    send_cmd(8'h70); read_dout(v);
    check(v == 8'h40, "R8 fail bit cleared", v, 8'h40);
    send_cmd(8'hFF);
    stays_ready("R10 second reset ignored");
  endtask

  task automatic t_cancel;
    send_cmd(8'h60); send_addr(8'h0C); send_addr(8'h00); send_cmd(8'h30);
    stays_ready("R11 no busy after cancel");
    check_block(3, 0, "R11 block 3 unchanged");
  endtask

  task automatic t_abort;
    int n; logic [7:0] v;
    start_erase(8'h0C, 8'h00);
    repeat (5) @(negedge clk);
    send_cmd(8'hFF);
    busy_len(n);
    check(n == RABORT, "R9 abort reset length", n, RABORT);
    send_cmd(8'h70); read_dout(v);
    check(v == 8'h40, "R9 ready after abort", v, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_fill();
    t_erase_basic();
    t_busy_filter();
    t_fail_and_reset();
    t_cancel();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule